// File: doc/BRIEF.md
# Synchronous Burst SRAM Model with Four-Beat Burst Engine

This block is a clocked memory model of a synchronous burst static RAM. Each word is split into byte lanes of nine bits, eight data bits with one parity bit on top. Every control input is sampled on the rising clock edge. Two address strobes start an access. The processor-side strobe always begins with a read. The controller-side strobe follows the write lines. Once an access has started, an advance input steps a two-bit burst counter through four beats, then wraps back to the start. The counter runs in linear or interleaved order, chosen by a mode input.

Three chip enables select or deselect the device. An output enable gates the read data without waiting for a clock edge. A sleep input parks the device. After sleep ends, strobes are ignored for a set number of recovery cycles. The data bus is split into an input word, an output word and an output-drive flag, so no bidirectional pad is needed. A surrounding test environment drives the memory as a bus master would, and treats the drive flag as the pad's enable.

Top module: `sbsram_core`

## Requirements
- R1: While reset is held and after it is released, `rdata_oe_o` is low and no burst is in progress until an address strobe starts one.
- R2: On an enabled edge where a strobe starts an access, the address is captured and the first beat uses it unchanged. Read data for any edge is on `rdata_o` after that edge, and `rdata_oe_o` is high from then until the next edge, provided `oe_n` is low.
- R3: With `order_sel` high, the two low address bits of beat k are the start bits XOR k. With it low, they are the start bits plus k modulo 4. The upper address bits never change within a burst.
- R4: On an edge with no strobe and a burst in progress, `adv_n` low moves to the next beat and `adv_n` high repeats the current beat. After the fourth beat the sequence wraps to the start address.
- R5: An access started by `proc_strobe_n` is a read even if the write lines are asserted. Later edges of that burst write when the write lines ask for it.
- R6: Write decode: `all_wr_n` low writes every lane. Otherwise `lane_wr_en_n` high is a read. With it low, lane i is written when `lane_wr_n[i]` is low, and the cycle is a read when every `lane_wr_n` bit is high.
- R7: Lane i occupies word bits [9i+8:9i], and its parity bit is bit 9i+8. Lane 0 is controlled by `lane_wr_n[0]` and lane 1 by `lane_wr_n[1]`. A write leaves unselected lanes unchanged.
- R8: An edge where a strobe acts while `sel1_n` is high, `sel2` is low or `sel3_n` is high deselects the device: the burst ends and `rdata_oe_o` is low after that edge.
- R9: After any write edge, and after any edge where nothing is accessed, `rdata_oe_o` is low whatever `oe_n` is.
- R10: `oe_n` high forces `rdata_oe_o` low at once, without waiting for a clock edge.
- R11: While `sleep_i` is high the burst ends and `rdata_oe_o` is low. For REC_CYC edges after `sleep_i` falls, strobes are ignored and the outputs stay off.
- R12: `proc_strobe_n` is ignored while `sel1_n` is high. On such an edge a low `ctrl_strobe_n` acts. Otherwise a burst in progress simply continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control sampled on rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr_i | input | ADDR_W | Word address captured by a strobe |
| sel1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, always starts a read |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, follows write lines |
| adv_n | input | 1 | Burst advance, low steps the burst |
| all_wr_n | input | 1 | Global write, low writes every lane |
| lane_wr_en_n | input | 1 | Enables per-lane write lines |
| lane_wr_n | input | LANES | Per-lane write, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | LANES*(LANE_DATA_W+1) | Write data word |
| rdata_o | output | LANES*(LANE_DATA_W+1) | Read data word |
| rdata_oe_o | output | 1 | High when the read data would drive the bus |

## Verification
The bench uses the defaults: 8 address bits (256 words), two lanes of 8+1 bits, REC_CYC of 2 and the order chosen at run time by pin. With only 256 words, every location is written and then known to the reference model, so every beat of every burst can be compared exactly. A two-cycle recovery is short enough for random sleep pulses to overlap strobes and burst continuations often. The run-time order pin lets a single build reach both burst orders, including a change of order in the middle of a burst.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sb_op_e;

   localparam int BURST_BITS = 2;

   // burst order variants chosen by ORDER_KIND
   localparam int ORDER_PIN    = 0;
   localparam int ORDER_LINEAR = 1;
   localparam int ORDER_XOR    = 2;
endpackage

// File: rtl/sbsram_ctl.sv
`timescale 1ns/1ps
module sbsram_ctl import sbsram_pkg::*; #(
   parameter int LANES   = 2,
   parameter int REC_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             sel3_n,
   input  logic             proc_strobe_n,
   input  logic             ctrl_strobe_n,
   input  logic             adv_n,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             sleep_i,
   output logic             load_o,
   output logic             step_o,
   output logic [LANES-1:0] lane_we_o,
   output logic             rd_en_o,
   output logic             valid_o
);
   localparam int RC_W = $clog2(REC_CYC + 1);

   logic [RC_W-1:0]  rec_q;
   logic             active_q, active_n;
   logic             valid_q;
   logic             ready, p_go, c_go, enabled, wr_any;
   logic [LANES-1:0] lane_req;
   sb_op_e           op;

   assign ready    = !sleep_i && (rec_q == '0);
   assign p_go     = !proc_strobe_n && !sel1_n;
   assign c_go     = !p_go && !ctrl_strobe_n;
   assign enabled  = !sel1_n && sel2 && !sel3_n;
   assign lane_req = {LANES{!all_wr_n}} | ({LANES{!lane_wr_en_n}} & ~lane_wr_n);
   assign wr_any   = |lane_req;

   always_comb begin
      load_o   = 1'b0;
      step_o   = 1'b0;
      op       = OP_NONE;
      active_n = active_q;
      if (!ready) begin
         active_n = 1'b0;
      end else if (p_go || c_go) begin
         if (enabled) begin
            load_o   = 1'b1;
            active_n = 1'b1;
            op       = (c_go && wr_any) ? OP_WRITE : OP_READ;
         end else begin
            active_n = 1'b0;
         end
      end else if (active_q) begin
         step_o = !adv_n;
         op     = wr_any ? OP_WRITE : OP_READ;
      end
   end

   assign lane_we_o = (op == OP_WRITE) ? lane_req : '0;
   assign rd_en_o   = (op == OP_READ);
   assign valid_o   = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_q    <= '0;
         active_q <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         if (sleep_i)
            rec_q <= RC_W'(REC_CYC);
         else if (rec_q != '0)
            rec_q <= rec_q - RC_W'(1);
         active_q <= active_n;
         valid_q  <= (op == OP_READ);
      end
   end
endmodule

// File: rtl/sbsram_seq.sv
`timescale 1ns/1ps
module sbsram_seq import sbsram_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter int ORDER_KIND = ORDER_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] eff_addr_o
);
   logic [ADDR_W-1:0]     base_q, base_n;
   logic [BURST_BITS-1:0] beat_q, beat_n, low;
   logic                  xor_order;

   generate
      if (ORDER_KIND == ORDER_PIN) begin : g_pin
         assign xor_order = order_sel;
      end else if (ORDER_KIND == ORDER_LINEAR) begin : g_lin
         assign xor_order = 1'b0;
      end else begin : g_xor
         assign xor_order = 1'b1;
      end
   endgenerate

   assign base_n = load_i ? addr_i : base_q;
   assign beat_n = load_i ? '0 : beat_q + {{(BURST_BITS-1){1'b0}}, step_i};
   assign low    = xor_order ? (base_n[BURST_BITS-1:0] ^ beat_n)
                             : (base_n[BURST_BITS-1:0] + beat_n);
   assign eff_addr_o = {base_n[ADDR_W-1:BURST_BITS], low};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else begin
         base_q <= base_n;
         beat_q <= beat_n;
      end
   end
endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES-1:0]        lane_we_i,
   input  logic                    rd_en_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   output logic [LANES*LANE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (lane_we_i[g])
               mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_q <= '0;
            else if (rd_en_i)
               rd_q <= mem[addr_i];
         end

         assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate
endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core import sbsram_pkg::*; #(
   parameter int ADDR_W      = 8,
   parameter int LANE_DATA_W = 8,
   parameter int LANES       = 2,
   parameter int REC_CYC     = 2,
   parameter int ORDER_KIND  = ORDER_PIN
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ADDR_W-1:0]                    addr_i,
   input  logic                                 sel1_n,
   input  logic                                 sel2,
   input  logic                                 sel3_n,
   input  logic                                 proc_strobe_n,
   input  logic                                 ctrl_strobe_n,
   input  logic                                 adv_n,
   input  logic                                 all_wr_n,
   input  logic                                 lane_wr_en_n,
   input  logic [LANES-1:0]                     lane_wr_n,
   input  logic                                 order_sel,
   input  logic                                 oe_n,
   input  logic                                 sleep_i,
   input  logic [LANES*(LANE_DATA_W+1)-1:0]     wdata_i,
   output logic [LANES*(LANE_DATA_W+1)-1:0]     rdata_o,
   output logic                                 rdata_oe_o
);
   localparam int LANE_W = LANE_DATA_W + 1;

   generate
      if (ADDR_W < BURST_BITS) begin : g_bad_addr
         $error("sbsram_core: ADDR_W must cover the burst bits");
      end
      if (LANES < 1 || LANE_DATA_W < 1) begin : g_bad_lane
         $error("sbsram_core: need at least one lane of one bit");
      end
      if (REC_CYC < 1) begin : g_bad_rec
         $error("sbsram_core: REC_CYC must be at least 1");
      end
      if (ORDER_KIND < ORDER_PIN || ORDER_KIND > ORDER_XOR) begin : g_bad_ord
         $error("sbsram_core: ORDER_KIND out of range");
      end
   endgenerate

   logic              load, step, rd_en, valid;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] eff_addr;

   sbsram_ctl #(.LANES(LANES), .REC_CYC(REC_CYC)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
      .adv_n(adv_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
      .lane_wr_n(lane_wr_n), .sleep_i(sleep_i),
      .load_o(load), .step_o(step), .lane_we_o(lane_we),
      .rd_en_o(rd_en), .valid_o(valid)
   );

   sbsram_seq #(.ADDR_W(ADDR_W), .ORDER_KIND(ORDER_KIND)) u_seq (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .addr_i(addr_i), .order_sel(order_sel), .eff_addr_o(eff_addr)
   );

   sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk(clk), .rst_n(rst_n), .addr_i(eff_addr), .lane_we_i(lane_we),
      .rd_en_i(rd_en), .wdata_i(wdata_i), .rdata_o(rdata_o)
   );

   assign rdata_oe_o = valid && !oe_n && !sleep_i;
endmodule

// File: rtl/sbsram_chk.sv
`timescale 1ns/1ps
module sbsram_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel1_n,
   input logic             sel2,
   input logic             sel3_n,
   input logic             proc_strobe_n,
   input logic             ctrl_strobe_n,
   input logic             all_wr_n,
   input logic             lane_wr_en_n,
   input logic [LANES-1:0] lane_wr_n,
   input logic             oe_n,
   input logic             sleep_i,
   input logic             rdata_oe_o
);
   // R8: a strobe that acts while deselected leaves nothing driven
   assert_desel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((!proc_strobe_n && !sel1_n) || !ctrl_strobe_n) && (sel1_n || !sel2 || sel3_n))
      |=> !rdata_oe_o);

   // R9: any edge carrying a write request never produces a driven read
   assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((proc_strobe_n || sel1_n) && (!all_wr_n || (!lane_wr_en_n && !(&lane_wr_n))))
      |=> !rdata_oe_o);

   // R10: output enable high keeps the bus released
   assert_oe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe_o);

   // R11: asleep now, or asleep at the previous edge, means released
   assert_sleep_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i || $past(sleep_i)) |-> !rdata_oe_o);

   // R11: the edge right after sleep ends is still in recovery
   assert_wake_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_i) |=> !rdata_oe_o);
endmodule

bind sbsram_core sbsram_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_sbsram_core.sv
`timescale 1ns/1ps
module sim_sbsram_core;
   localparam int AW = 8;
   localparam int NW = 1 << AW;
   localparam int REC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr_i = '0;
   logic        sel1_n, sel2, sel3_n, proc_strobe_n, ctrl_strobe_n, adv_n;
   logic        all_wr_n, lane_wr_en_n, order_sel, oe_n, sleep_i;
   logic [1:0]  lane_wr_n;
   logic [17:0] wdata_i = '0;
   logic [17:0] rdata_o;
   logic        rdata_oe_o;

   int vectors = 0;
   int bad = 0;
   bit done = 0;

   // reference model state
   logic [17:0] ref_mem [NW];
   bit          m_act = 0, m_val = 0;
   int          m_base = 0, m_beat = 0, m_rec = 0;
   logic [17:0] m_rd = '0;

   always #2 clk = ~clk;

   sbsram_core u0 (.*);

   task automatic quiet();
      sel1_n = 0; sel2 = 1; sel3_n = 0;
      proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1;
      all_wr_n = 1; lane_wr_en_n = 1; lane_wr_n = 2'b11;
      oe_n = 0; sleep_i = 0;
   endtask

   task automatic access(bit wr);
      int a;
      int lo;
      lo = (order_sel) ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
      a  = (m_base & ~3) | lo;
      if (wr) begin
         if (!all_wr_n || (!lane_wr_en_n && !lane_wr_n[0])) ref_mem[a][8:0]  = wdata_i[8:0];
         if (!all_wr_n || (!lane_wr_en_n && !lane_wr_n[1])) ref_mem[a][17:9] = wdata_i[17:9];
         m_val = 0;
      end else begin
         m_val = 1;
         m_rd  = ref_mem[a];
      end
   endtask

   task automatic model_edge();
      bit pgo, cgo, en, wr;
      if (sleep_i) begin
         m_act = 0; m_val = 0; m_rec = REC;
      end else if (m_rec > 0) begin
         m_rec--; m_act = 0; m_val = 0;
      end else begin
         pgo = !proc_strobe_n && !sel1_n;
         cgo = !pgo && !ctrl_strobe_n;
         en  = !sel1_n && sel2 && !sel3_n;
         wr  = !all_wr_n || (!lane_wr_en_n && lane_wr_n != 2'b11);
         if (pgo || cgo) begin
            if (en) begin
               m_base = int'(addr_i); m_beat = 0; m_act = 1;
               access(cgo && wr);
            end else begin
               m_act = 0; m_val = 0;
            end
         end else if (m_act) begin
            if (!adv_n) m_beat = (m_beat + 1) % 4;
            access(wr);
         end else begin
            m_val = 0;
         end
      end
   endtask

   task automatic compare(string tag);
      bit exp_oe;
      exp_oe = m_val && !oe_n && !sleep_i;
      vectors++;
      if (rdata_oe_o !== exp_oe) begin
         bad++;
         $display("FAIL %s: rdata_oe_o=%b expected %b at %0t", tag, rdata_oe_o, exp_oe, $time);
      end else if (exp_oe && rdata_o !== m_rd) begin
         bad++;
         $display("FAIL %s: rdata_o=%h expected %h at %0t", tag, rdata_o, m_rd, $time);
      end
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   // strobe helpers (inputs change only at the falling edge)
   task automatic p_read(int a, string tag);
      quiet(); proc_strobe_n = 0; addr_i = 8'(a); step(tag);
   endtask

   task automatic adv(int n, string tag);
      for (int i = 0; i < n; i++) begin
         quiet(); adv_n = 0; step(tag);
      end
   endtask

   initial begin
      quiet();
      order_sel = 0;
      // R1: outputs released during and after reset
      repeat (3) @(negedge clk);
      vectors++;
      if (rdata_oe_o !== 1'b0) begin
         bad++; $display("FAIL R1: rdata_oe_o=%b expected 0 in reset", rdata_oe_o);
      end
      rst_n = 1;
      step("R1");
      step("R1");

      // fill every word with single controller-strobe writes (R6 global write)
      for (int a = 0; a < NW; a++) begin
         quiet(); ctrl_strobe_n = 0; all_wr_n = 0; addr_i = 8'(a);
         wdata_i = 18'($urandom);
         step("R6");
      end

      // R2 R3 R4: linear burst from low bits 01, wraps after four
      order_sel = 0;
      p_read(8'h25, "R2");
      adv(5, "R3");
      // R3 R4: interleaved burst from low bits 10
      order_sel = 1;
      p_read(8'h36, "R2");
      adv(5, "R3");
      // R4: suspend holds the current beat
      p_read(8'h47, "R4");
      adv(1, "R4");
      quiet(); step("R4"); step("R4");
      adv(2, "R4");

      // R5: processor strobe ignores write lines, then a later edge writes
      quiet(); proc_strobe_n = 0; all_wr_n = 0; addr_i = 8'h50; wdata_i = 18'h2AAAA;
      step("R5");
      quiet(); adv_n = 0; all_wr_n = 0; wdata_i = 18'h15555; step("R5");
      p_read(8'h50, "R5"); adv(1, "R5");

      // R6 R7: per-lane writes via controller strobe, then read back
      order_sel = 0;
      quiet(); ctrl_strobe_n = 0; lane_wr_en_n = 0; lane_wr_n = 2'b10;
      addr_i = 8'h60; wdata_i = 18'h3FE01; step("R7");
      quiet(); ctrl_strobe_n = 0; lane_wr_en_n = 0; lane_wr_n = 2'b01;
      addr_i = 8'h61; wdata_i = 18'h201FF; step("R7");
      quiet(); ctrl_strobe_n = 0; lane_wr_en_n = 0; lane_wr_n = 2'b11;
      addr_i = 8'h62; wdata_i = 18'h0; step("R6");
      quiet(); ctrl_strobe_n = 0; lane_wr_en_n = 1; lane_wr_n = 2'b00;
      addr_i = 8'h63; wdata_i = 18'h0; step("R6");
      quiet(); ctrl_strobe_n = 0; all_wr_n = 0; lane_wr_en_n = 1;
      addr_i = 8'h64; wdata_i = 18'h1C3C3; step("R6");
      p_read(8'h60, "R7"); adv(4, "R7");

      // R8: deselect through each enable
      p_read(8'h70, "R8");
      quiet(); ctrl_strobe_n = 0; sel2 = 0; step("R8");
      quiet(); adv_n = 0; step("R8");
      p_read(8'h71, "R8");
      quiet(); proc_strobe_n = 0; sel3_n = 1; step("R8");
      p_read(8'h72, "R8");
      quiet(); ctrl_strobe_n = 0; sel1_n = 1; step("R8");
      step("R9");

      // R12: processor strobe ignored with sel1_n high, burst goes on
      p_read(8'h80, "R12");
      quiet(); proc_strobe_n = 0; sel1_n = 1; adv_n = 0; addr_i = 8'h90; step("R12");
      adv(1, "R12");

      // R10: output enable acts without a clock edge
      p_read(8'hA0, "R10");
      oe_n = 1; #0.5;
      vectors++;
      if (rdata_oe_o !== 1'b0) begin
         bad++; $display("FAIL R10: rdata_oe_o=%b expected 0 right after oe_n high", rdata_oe_o);
      end
      oe_n = 0; #0.5;
      vectors++;
      if (rdata_oe_o !== 1'b1) begin
         bad++; $display("FAIL R10: rdata_oe_o=%b expected 1 right after oe_n low", rdata_oe_o);
      end
      @(negedge clk);

      // R11: sleep in a burst, strobes ignored during recovery
      p_read(8'hB0, "R11");
      quiet(); sleep_i = 1; proc_strobe_n = 0; addr_i = 8'hB4; step("R11"); step("R11");
      quiet(); proc_strobe_n = 0; addr_i = 8'hB8; step("R11");
      quiet(); adv_n = 0; step("R11");
      p_read(8'hBC, "R11"); adv(1, "R11");

      // R9: write in a burst releases the bus; idle edges release it too
      p_read(8'hC0, "R9");
      quiet(); lane_wr_en_n = 0; lane_wr_n = 2'b00; wdata_i = 18'h0F0F0; step("R9");
      quiet(); step("R9"); step("R9");

      // mixed random traffic against the reference model
      for (int i = 0; i < 4000; i++) begin
         sel1_n        = ($urandom % 10) == 0;
         sel2          = ($urandom % 10) != 0;
         sel3_n        = ($urandom % 10) == 0;
         proc_strobe_n = ($urandom % 5) != 0;
         ctrl_strobe_n = ($urandom % 5) != 0;
         adv_n         = ($urandom % 3) == 0;
         all_wr_n      = ($urandom % 6) != 0;
         lane_wr_en_n  = ($urandom % 2) == 0;
         lane_wr_n     = 2'($urandom);
         oe_n          = ($urandom % 8) == 0;
         sleep_i       = ($urandom % 50) == 0;
         if (($urandom % 16) == 0) order_sel = ~order_sel;
         addr_i        = 8'($urandom);
         wdata_i       = 18'($urandom);
         step("R3");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   end
endmodule